// File: doc/BRIEF.md
# Configuration Access Translator

This block sits between the processor side of a host bridge and the internal configuration fabric. Two access paths reach the configuration space of every bus, device and function. The first is a pair of 32-bit I/O ports: an address register that selects a target, and a data window that reads or writes the selected dword. The second is a memory-mapped window. Its address bits carry the target directly, and it can reach the full 4 KB of space per function.

Both paths are turned into one internal request. The request carries the bus, device, function, dword offset, byte enables, direction and write data. Read data from the fabric goes back to whichever path issued the read. The block answers some accesses by itself: reads of the address register, reads of the data window while the enable bit is clear, reads of unclaimed ports, and rejected memory accesses.

Only one read may be outstanding at a time. While a read is waiting, both ready outputs are low.

Top module: `cfg_access_xlate`

## Requirements
- R1: Only a write to I/O port 0x0CF8 with all four byte enables set loads the address register. The stored value keeps bit 31 and bits [23:2]; bits [30:24] and [1:0] are stored as zero. A read of any port from 0x0CF8 to 0x0CFB returns the stored value on io_rdata, with io_rvalid, one cycle after acceptance.
- R2: An access to ports 0x0CFC to 0x0CFF while address-register bit 31 is 1 issues a request one cycle after acceptance. The request fields are: bus = bits [23:16], device = [15:11], function = [10:8], and req_dword = bits [7:2] with its upper four bits zero. Byte enables, write data and direction are taken from the I/O access.
- R3: While address-register bit 31 is 0, a read of the data window returns 0xFFFFFFFF one cycle after acceptance, and a write to it issues no request.
- R4: A memory access inside the window is legal when mm_addr[31:28] equals cfg_win_base, mm_size is 2 (four bytes), mm_addr[1:0] is 0 and mm_lock is 0. A legal access issues a request one cycle later with bus = [27:20], device = [19:15], function = [14:12] and req_dword = [11:2]. This covers offsets up to 4095.
- R5: A memory access that is misaligned, not four bytes, locked, or outside the window raises mm_err for one cycle, one cycle after acceptance, and issues no request. If the rejected access is a read, it also returns 0xFFFFFFFF with mm_rvalid.
- R6: A write to the same target through either path yields an identical request: the same bus, device, function, dword, byte enables and data.
- R7: When rsp_valid arrives while a read is outstanding, rsp_rdata is returned one cycle later, on the rvalid and rdata of the path that issued the read and only that path.
- R8: From the cycle after a read is issued until its response is taken, io_ready and mm_ready are low. When io_valid and mm_valid are both high, the I/O access is accepted and mm_ready is low.
- R9: A read of an I/O port outside 0x0CF8 to 0x0CFF returns 0xFFFFFFFF one cycle after acceptance and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_win_base | input | 4 | Address bits [31:28] of the memory-mapped window |
| io_valid | input | 1 | I/O access present |
| io_ready | output | 1 | I/O access accepted this cycle if valid |
| io_write | input | 1 | I/O access is a write |
| io_addr | input | 16 | I/O port address |
| io_be | input | 4 | Dword lane enables |
| io_wdata | input | 32 | I/O write data |
| io_rvalid | output | 1 | I/O read data valid |
| io_rdata | output | 32 | I/O read data |
| mm_valid | input | 1 | Memory access present |
| mm_ready | output | 1 | Memory access accepted this cycle if valid |
| mm_write | input | 1 | Memory access is a write |
| mm_lock | input | 1 | Memory access is locked |
| mm_size | input | 2 | Access size: 0=1, 1=2, 2=4, 3=8 bytes |
| mm_addr | input | 32 | Memory byte address |
| mm_be | input | 4 | Dword lane enables |
| mm_wdata | input | 32 | Memory write data |
| mm_rvalid | output | 1 | Memory read data valid |
| mm_rdata | output | 32 | Memory read data |
| mm_err | output | 1 | Memory access rejected |
| req_valid | output | 1 | Configuration request valid |
| req_write | output | 1 | Request is a write |
| req_bus | output | 8 | Target bus |
| req_dev | output | 5 | Target device |
| req_func | output | 3 | Target function |
| req_dword | output | 10 | Target dword offset |
| req_be | output | 4 | Request byte enables |
| req_wdata | output | 32 | Request write data |
| rsp_valid | input | 1 | Read response from fabric |
| rsp_rdata | input | 32 | Read response data |

## Verification
Several results come one registered stage after the accepting edge: requests, local answers and error pulses. The bench drives inputs on a falling edge, removes them at the next falling edge, and samples the results at that same point, after the single stage has updated. Fabric responses are driven for one cycle once a read request is seen. The routed data is due one edge later, and the bench samples it at the next falling edge, after checking that both ready outputs are low in the waiting cycle. The sweeps cover every device and function, and the expected values are computed from the field positions.

// File: rtl/cfg_xlate_pkg.sv
// Shared widths and the internal configuration request format.
package cfg_xlate_pkg;
    localparam int BUS_W    = 8;
    localparam int DEV_W    = 5;
    localparam int FUNC_W   = 3;
    localparam int DW_W     = 10;   // dword offset in 4 KB space
    localparam int LEG_DW_W = 6;    // dword offset in 256 B space
    localparam int DATA_W   = 32;
    localparam int BE_W     = DATA_W / 8;

    typedef struct packed {
        logic              write;
        logic [BUS_W-1:0]  bus;
        logic [DEV_W-1:0]  dev;
        logic [FUNC_W-1:0] func;
        logic [DW_W-1:0]   dw;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] wdata;
    } cfg_req_t;
endpackage

// File: rtl/cfg_legacy_port.sv
// Legacy port pair: holds the address register and decodes the data window.
// Assumes io_accept is high only for a presented access that the issue stage
// takes this cycle. Produces a request candidate or a local read answer.
module cfg_legacy_port
    import cfg_xlate_pkg::*;
#(
    parameter int             IO_W      = 16,
    parameter logic [IO_W-1:0] ADDR_PORT = 16'h0CF8,
    parameter logic [IO_W-1:0] DATA_PORT = 16'h0CFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [IO_W-1:0]   io_addr,
    input  logic [BE_W-1:0]   io_be,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_accept,
    output logic              cand_valid,
    output cfg_req_t          cand,
    output logic              loc_rd,
    output logic [DATA_W-1:0] loc_rdata
);
    localparam int ENA_BIT  = DATA_W - 1;
    localparam int REG_LSB  = 2;
    localparam int FUNC_LSB = REG_LSB + LEG_DW_W;
    localparam int DEV_LSB  = FUNC_LSB + FUNC_W;
    localparam int BUS_LSB  = DEV_LSB + DEV_W;
    localparam int TOP_FLD  = BUS_LSB + BUS_W;
    localparam logic [DATA_W-1:0] KEEP_MASK =
        {1'b1, {(DATA_W-1-TOP_FLD){1'b0}}, {(TOP_FLD-REG_LSB){1'b1}}, {REG_LSB{1'b0}}};

    logic [DATA_W-1:0] addr_q;
    logic              hit_addr;
    logic              hit_data;

    // Load the address register on a full-dword write to its port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (io_accept && io_write && io_addr == ADDR_PORT && io_be == '1) begin
            addr_q <= io_wdata & KEEP_MASK;
        end
    end

    // Decode the port range and build the request candidate.
    always_comb begin
        hit_addr   = io_addr[IO_W-1:REG_LSB] == ADDR_PORT[IO_W-1:REG_LSB];
        hit_data   = io_addr[IO_W-1:REG_LSB] == DATA_PORT[IO_W-1:REG_LSB];
        cand_valid = io_valid && hit_data && addr_q[ENA_BIT];
        cand       = '0;
        cand.write = io_write;
        cand.bus   = addr_q[BUS_LSB +: BUS_W];
        cand.dev   = addr_q[DEV_LSB +: DEV_W];
        cand.func  = addr_q[FUNC_LSB +: FUNC_W];
        cand.dw[LEG_DW_W-1:0] = addr_q[REG_LSB +: LEG_DW_W];
        cand.be    = io_be;
        cand.wdata = io_wdata;
        loc_rd     = io_valid && !io_write && !cand_valid;
        loc_rdata  = hit_addr ? addr_q : '1;
    end
endmodule

// File: rtl/cfg_mmio_decode.sv
// Memory-mapped window decode: checks legality and extracts the target.
// Assumes the window is aligned to its own size, selected by the top address bits.
module cfg_mmio_decode
    import cfg_xlate_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                         mm_valid,
    input  logic                         mm_write,
    input  logic                         mm_lock,
    input  logic [1:0]                   mm_size,
    input  logic [ADDR_W-1:0]            mm_addr,
    input  logic [BE_W-1:0]              mm_be,
    input  logic [DATA_W-1:0]            mm_wdata,
    input  logic [ADDR_W-(BUS_W+DEV_W+FUNC_W+DW_W+2)-1:0] win_base,
    output logic                         cand_valid,
    output cfg_req_t                     cand,
    output logic                         bad
);
    localparam int DW_LSB   = 2;
    localparam int FUNC_LSB = DW_LSB + DW_W;
    localparam int DEV_LSB  = FUNC_LSB + FUNC_W;
    localparam int BUS_LSB  = DEV_LSB + DEV_W;
    localparam int WIN_W    = BUS_LSB + BUS_W;
    localparam logic [1:0] SIZE_DWORD = 2'd2;

    logic in_win;
    logic legal;

    // Check the access shape and pull the target fields from the address.
    always_comb begin
        in_win     = mm_addr[ADDR_W-1:WIN_W] == win_base;
        legal      = in_win && mm_size == SIZE_DWORD &&
                     mm_addr[DW_LSB-1:0] == '0 && !mm_lock;
        cand_valid = mm_valid && legal;
        bad        = mm_valid && !legal;
        cand.write = mm_write;
        cand.bus   = mm_addr[BUS_LSB +: BUS_W];
        cand.dev   = mm_addr[DEV_LSB +: DEV_W];
        cand.func  = mm_addr[FUNC_LSB +: FUNC_W];
        cand.dw    = mm_addr[DW_LSB +: DW_W];
        cand.be    = mm_be;
        cand.wdata = mm_wdata;
    end
endmodule

// File: rtl/cfg_req_issue.sv
// Issue stage: arbitrates the two paths, registers the request, tracks the one
// outstanding read and routes answers back. The I/O path wins a same-cycle tie.
module cfg_req_issue
    import cfg_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_valid,
    input  logic              io_cand_valid,
    input  cfg_req_t          io_cand,
    input  logic              io_loc_rd,
    input  logic [DATA_W-1:0] io_loc_rdata,
    input  logic              mm_valid,
    input  logic              mm_write,
    input  logic              mm_cand_valid,
    input  cfg_req_t          mm_cand,
    input  logic              mm_bad,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_rdata,
    output logic              io_accept,
    output logic              io_ready,
    output logic              mm_ready,
    output logic              req_valid,
    output cfg_req_t          req,
    output logic              io_rvalid,
    output logic [DATA_W-1:0] io_rdata,
    output logic              mm_rvalid,
    output logic [DATA_W-1:0] mm_rdata,
    output logic              mm_err
);
    logic pend_q;
    logic owner_mm_q;
    logic mm_accept;
    logic issue_io;
    logic issue_mm;
    logic rsp_hit;

    // Acceptance and issue decisions for this cycle.
    always_comb begin
        io_ready  = !pend_q;
        mm_ready  = !pend_q && !io_valid;
        io_accept = io_valid && io_ready;
        mm_accept = mm_valid && mm_ready;
        issue_io  = io_accept && io_cand_valid;
        issue_mm  = mm_accept && mm_cand_valid;
        rsp_hit   = pend_q && rsp_valid;
    end

    // Track the single outstanding read and which path owns it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            owner_mm_q <= 1'b0;
        end else if (issue_io && !io_cand.write) begin
            pend_q     <= 1'b1;
            owner_mm_q <= 1'b0;
        end else if (issue_mm && !mm_cand.write) begin
            pend_q     <= 1'b1;
            owner_mm_q <= 1'b1;
        end else if (rsp_hit) begin
            pend_q     <= 1'b0;
        end
    end

    // Register the outgoing request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            req       <= '0;
        end else begin
            req_valid <= issue_io || issue_mm;
            req       <= issue_mm ? mm_cand : io_cand;
        end
    end

    // Register answers to the I/O requester.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_rvalid <= 1'b0;
            io_rdata  <= '0;
        end else begin
            io_rvalid <= (io_accept && io_loc_rd) || (rsp_hit && !owner_mm_q);
            io_rdata  <= rsp_hit ? rsp_rdata : io_loc_rdata;
        end
    end

    // Register answers and rejections for the memory requester.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mm_rvalid <= 1'b0;
            mm_rdata  <= '0;
            mm_err    <= 1'b0;
        end else begin
            mm_rvalid <= (mm_accept && mm_bad && !mm_write) || (rsp_hit && owner_mm_q);
            mm_rdata  <= rsp_hit ? rsp_rdata : '1;
            mm_err    <= mm_accept && mm_bad;
        end
    end
endmodule

// File: rtl/cfg_access_xlate.sv
// Top: joins the legacy port pair and the memory window into one request stream.
// Assumes the fabric answers each read request exactly once through rsp_valid.
module cfg_access_xlate
    import cfg_xlate_pkg::*;
#(
    parameter int IO_W   = 16,
    parameter int ADDR_W = 32,
    localparam int BASE_W = ADDR_W - (BUS_W + DEV_W + FUNC_W + DW_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BASE_W-1:0] cfg_win_base,
    input  logic              io_valid,
    output logic              io_ready,
    input  logic              io_write,
    input  logic [IO_W-1:0]   io_addr,
    input  logic [BE_W-1:0]   io_be,
    input  logic [DATA_W-1:0] io_wdata,
    output logic              io_rvalid,
    output logic [DATA_W-1:0] io_rdata,
    input  logic              mm_valid,
    output logic              mm_ready,
    input  logic              mm_write,
    input  logic              mm_lock,
    input  logic [1:0]        mm_size,
    input  logic [ADDR_W-1:0] mm_addr,
    input  logic [BE_W-1:0]   mm_be,
    input  logic [DATA_W-1:0] mm_wdata,
    output logic              mm_rvalid,
    output logic [DATA_W-1:0] mm_rdata,
    output logic              mm_err,
    output logic              req_valid,
    output logic              req_write,
    output logic [BUS_W-1:0]  req_bus,
    output logic [DEV_W-1:0]  req_dev,
    output logic [FUNC_W-1:0] req_func,
    output logic [DW_W-1:0]   req_dword,
    output logic [BE_W-1:0]   req_be,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_rdata
);
    logic              io_accept;
    logic              io_cand_valid;
    cfg_req_t          io_cand;
    logic              io_loc_rd;
    logic [DATA_W-1:0] io_loc_rdata;
    logic              mm_cand_valid;
    cfg_req_t          mm_cand;
    logic              mm_bad;
    cfg_req_t          req;

    cfg_legacy_port #(.IO_W(IO_W)) u_legacy (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_valid   (io_valid),
        .io_write   (io_write),
        .io_addr    (io_addr),
        .io_be      (io_be),
        .io_wdata   (io_wdata),
        .io_accept  (io_accept),
        .cand_valid (io_cand_valid),
        .cand       (io_cand),
        .loc_rd     (io_loc_rd),
        .loc_rdata  (io_loc_rdata)
    );

    cfg_mmio_decode #(.ADDR_W(ADDR_W)) u_mmio (
        .mm_valid   (mm_valid),
        .mm_write   (mm_write),
        .mm_lock    (mm_lock),
        .mm_size    (mm_size),
        .mm_addr    (mm_addr),
        .mm_be      (mm_be),
        .mm_wdata   (mm_wdata),
        .win_base   (cfg_win_base),
        .cand_valid (mm_cand_valid),
        .cand       (mm_cand),
        .bad        (mm_bad)
    );

    cfg_req_issue u_issue (
        .clk           (clk),
        .rst_n         (rst_n),
        .io_valid      (io_valid),
        .io_cand_valid (io_cand_valid),
        .io_cand       (io_cand),
        .io_loc_rd     (io_loc_rd),
        .io_loc_rdata  (io_loc_rdata),
        .mm_valid      (mm_valid),
        .mm_write      (mm_write),
        .mm_cand_valid (mm_cand_valid),
        .mm_cand       (mm_cand),
        .mm_bad        (mm_bad),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .io_accept     (io_accept),
        .io_ready      (io_ready),
        .mm_ready      (mm_ready),
        .req_valid     (req_valid),
        .req           (req),
        .io_rvalid     (io_rvalid),
        .io_rdata      (io_rdata),
        .mm_rvalid     (mm_rvalid),
        .mm_rdata      (mm_rdata),
        .mm_err        (mm_err)
    );

    // Flatten the request record onto the output ports.
    always_comb begin
        req_write = req.write;
        req_bus   = req.bus;
        req_dev   = req.dev;
        req_func  = req.func;
        req_dword = req.dw;
        req_be    = req.be;
        req_wdata = req.wdata;
    end
endmodule

// File: rtl/cfg_access_xlate_chk.sv
// Port-level protocol checks for cfg_access_xlate, attached through bind.
module cfg_access_xlate_chk
    import cfg_xlate_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            io_valid,
    input logic            io_ready,
    input logic            mm_valid,
    input logic            mm_ready,
    input logic            mm_lock,
    input logic            io_rvalid,
    input logic            mm_rvalid,
    input logic            mm_err,
    input logic            req_valid,
    input logic            req_write,
    input logic [DW_W-1:0] req_dword,
    input logic            rsp_valid
);
    AST_LEGACY_NO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && $past(io_valid && io_ready) |-> req_dword[DW_W-1:LEG_DW_W] == '0); // R2

    AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mm_err |-> !req_valid); // R5

    AST_LOCK_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        mm_valid && mm_ready && mm_lock |=> mm_err && !req_valid); // R5

    AST_RSP_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !io_ready |=> io_rvalid != mm_rvalid); // R7

    AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rvalid && mm_rvalid)); // R7

    AST_READY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        mm_ready |-> io_ready); // R8

    AST_READ_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |-> !io_ready && !mm_ready); // R8
endmodule

bind cfg_access_xlate cfg_access_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_valid  (io_valid),
    .io_ready  (io_ready),
    .mm_valid  (mm_valid),
    .mm_ready  (mm_ready),
    .mm_lock   (mm_lock),
    .io_rvalid (io_rvalid),
    .mm_rvalid (mm_rvalid),
    .mm_err    (mm_err),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_dword (req_dword),
    .rsp_valid (rsp_valid)
);

// File: tb/tb_cfg_access_xlate.sv
module tb_cfg_access_xlate;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam logic [3:0] WBASE = 4'hE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_win_base = WBASE;
    logic        io_valid = 0, io_write = 0;
    logic [15:0] io_addr = '0;
    logic [3:0]  io_be = '0;
    logic [31:0] io_wdata = '0;
    logic        io_ready, io_rvalid;
    logic [31:0] io_rdata;
    logic        mm_valid = 0, mm_write = 0, mm_lock = 0;
    logic [1:0]  mm_size = 2'd2;
    logic [31:0] mm_addr = '0;
    logic [3:0]  mm_be = '0;
    logic [31:0] mm_wdata = '0;
    logic        mm_ready, mm_rvalid, mm_err;
    logic [31:0] mm_rdata;
    logic        req_valid, req_write;
    logic [7:0]  req_bus;
    logic [4:0]  req_dev;
    logic [2:0]  req_func;
    logic [9:0]  req_dword;
    logic [3:0]  req_be;
    logic [31:0] req_wdata;
    logic        rsp_valid = 0;
    logic [31:0] rsp_rdata = '0;

    int checks = 0;
    int fails  = 0;

    // snapshots
    logic        s_req_valid, s_req_write, s_ready, s_rvalid, s_err;
    logic [7:0]  s_bus;
    logic [4:0]  s_dev;
    logic [2:0]  s_func;
    logic [9:0]  s_dw;
    logic [3:0]  s_be;
    logic [31:0] s_wdata, s_rdata;

    cfg_access_xlate dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] exp_rsp(input logic [7:0] b, input logic [4:0] d,
                                            input logic [2:0] f, input logic [9:0] w);
        return {b, d, f, w, 6'h2A} ^ 32'h1357_9BDF;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic snap_req();
        s_req_valid = req_valid; s_req_write = req_write;
        s_bus = req_bus; s_dev = req_dev; s_func = req_func; s_dw = req_dword;
        s_be = req_be; s_wdata = req_wdata;
    endtask

    task automatic answer_read(input logic is_mm);
        if (req_valid && !req_write) begin
            rsp_valid = 1'b1;
            rsp_rdata = exp_rsp(req_bus, req_dev, req_func, req_dword);
            @(negedge clk);
            rsp_valid = 1'b0;
            s_rvalid = is_mm ? mm_rvalid : io_rvalid;
            s_rdata  = is_mm ? mm_rdata : io_rdata;
        end
    endtask

    task automatic io_cyc(input logic w, input logic [15:0] a, input logic [3:0] be,
                          input logic [31:0] d);
        @(negedge clk);
        io_valid = 1'b1; io_write = w; io_addr = a; io_be = be; io_wdata = d;
        @(negedge clk);
        io_valid = 1'b0;
        snap_req();
        s_ready = io_ready; s_rvalid = io_rvalid; s_rdata = io_rdata;
        answer_read(1'b0);
    endtask

    task automatic mm_cyc(input logic w, input logic lk, input logic [1:0] sz,
                          input logic [31:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        mm_valid = 1'b1; mm_write = w; mm_lock = lk; mm_size = sz;
        mm_addr = a; mm_be = be; mm_wdata = d;
        @(negedge clk);
        mm_valid = 1'b0; mm_lock = 1'b0;
        snap_req();
        s_ready = mm_ready; s_err = mm_err; s_rvalid = mm_rvalid; s_rdata = mm_rdata;
        answer_read(1'b1);
    endtask

    function automatic logic [31:0] mk_addr(input logic [7:0] b, input logic [4:0] d,
                                            input logic [2:0] f, input logic [5:0] r);
        return {1'b1, 7'h55, b, d, f, r, 2'b11};
    endfunction

    function automatic logic [31:0] mm_target(input logic [7:0] b, input logic [4:0] d,
                                              input logic [2:0] f, input logic [9:0] w);
        return {WBASE, b, d, f, w, 2'b00};
    endfunction

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish (got timeout, expected completion)");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R1, R8)
        chk("R8 reset io_ready", 32'(io_ready), 32'd1);
        chk("R8 reset mm_ready", 32'(mm_ready), 32'd1);
        chk("R2 reset req_valid", 32'(req_valid), 32'd0);
        chk("R5 reset mm_err", 32'(mm_err), 32'd0);
        io_cyc(1'b0, 16'h0CF8, 4'hF, '0);
        chk("R1 reset addr readback", s_rdata, 32'h0);
        chk("R1 readback valid", 32'(s_rvalid), 32'd1);

        // R1: full write keeps only defined bits; partial write ignored
        io_cyc(1'b1, 16'h0CF8, 4'hF, 32'hFFFF_FFFF);
        io_cyc(1'b0, 16'h0CFA, 4'hF, '0);
        chk("R1 masked readback", s_rdata, 32'h80FF_FFFC);
        io_cyc(1'b1, 16'h0CF8, 4'h3, 32'h0000_0000);
        io_cyc(1'b0, 16'h0CF8, 4'hF, '0);
        chk("R1 partial write ignored", s_rdata, 32'h80FF_FFFC);

        // R3: enable clear
        io_cyc(1'b1, 16'h0CF8, 4'hF, 32'h0001_0804);
        io_cyc(1'b0, 16'h0CFC, 4'hF, '0);
        chk("R3 disabled read data", s_rdata, 32'hFFFF_FFFF);
        chk("R3 disabled read no req", 32'(s_req_valid), 32'd0);
        io_cyc(1'b1, 16'h0CFC, 4'hF, 32'h1234_5678);
        chk("R3 disabled write no req", 32'(s_req_valid), 32'd0);

        // R9: other port
        io_cyc(1'b0, 16'h0080, 4'hF, '0);
        chk("R9 other port data", s_rdata, 32'hFFFF_FFFF);
        chk("R9 other port no req", 32'(s_req_valid), 32'd0);

        // R2 / R7 / R8 sweep over devices and functions via legacy path
        for (int d = 0; d < 32; d++) begin
            for (int f = 0; f < 8; f++) begin
                logic [7:0] b;
                logic [5:0] r;
                logic [3:0] wbe;
                b = 8'(d * 9 + f);
                r = 6'(d * 2 + f * 5);
                wbe = 4'(d + f);
                io_cyc(1'b1, 16'h0CF8, 4'hF, mk_addr(b, 5'(d), 3'(f), r));
                io_cyc(1'b0, 16'h0CFC, 4'hF, '0);
                chk("R2 read req valid", 32'(s_req_valid), 32'd1);
                chk("R2 read req fields", {s_req_write, s_bus, s_dev, s_func, s_dw},
                    {1'b0, b, 5'(d), 3'(f), 4'b0, r});
                chk("R8 busy during read", 32'(s_ready), 32'd0);
                chk("R7 io read data", s_rdata, exp_rsp(b, 5'(d), 3'(f), {4'b0, r}));
                io_cyc(1'b1, 16'h0CFE, wbe, 32'(d * 1000 + f));
                chk("R2 write req", {s_req_valid, s_req_write, s_be},
                    {1'b1, 1'b1, wbe});
                chk("R2 write data", s_wdata, 32'(d * 1000 + f));
            end
        end

        // R4 / R7 sweep through memory window, including extended offsets
        for (int d = 0; d < 32; d++) begin
            for (int f = 0; f < 8; f++) begin
                logic [7:0] b;
                logic [9:0] w;
                b = 8'(255 - d * 7 - f);
                w = 10'(d * 37 + f * 101);
                mm_cyc(1'b0, 1'b0, 2'd2, mm_target(b, 5'(d), 3'(f), w), 4'hF, '0);
                chk("R4 mm read req", {s_req_valid, s_req_write, s_bus, s_dev, s_func, s_dw},
                    {1'b1, 1'b0, b, 5'(d), 3'(f), w});
                chk("R7 mm read data", s_rdata, exp_rsp(b, 5'(d), 3'(f), w));
                chk("R7 mm rvalid", 32'(s_rvalid), 32'd1);
                chk("R5 legal no err", 32'(s_err), 32'd0);
            end
        end

        // R5: rejected memory accesses
        mm_cyc(1'b0, 1'b0, 2'd2, mm_target(8'd1, 5'd2, 3'd3, 10'd4) | 32'd1, 4'hF, '0);
        chk("R5 misaligned err", {s_err, s_req_valid, s_rvalid}, {1'b1, 1'b0, 1'b1});
        chk("R5 misaligned data", s_rdata, 32'hFFFF_FFFF);
        mm_cyc(1'b1, 1'b0, 2'd1, mm_target(8'd1, 5'd2, 3'd3, 10'd4), 4'h3, 32'h5);
        chk("R5 narrow write err", {s_err, s_req_valid, s_rvalid}, {1'b1, 1'b0, 1'b0});
        mm_cyc(1'b0, 1'b0, 2'd3, mm_target(8'd1, 5'd2, 3'd3, 10'd4), 4'hF, '0);
        chk("R5 wide read err", {s_err, s_req_valid}, {1'b1, 1'b0});
        mm_cyc(1'b0, 1'b1, 2'd2, mm_target(8'd1, 5'd2, 3'd3, 10'd4), 4'hF, '0);
        chk("R5 locked err", {s_err, s_req_valid}, {1'b1, 1'b0});
        chk("R5 locked data", s_rdata, 32'hFFFF_FFFF);
        mm_cyc(1'b1, 1'b0, 2'd2, 32'hD000_0000, 4'hF, 32'h9);
        chk("R5 outside window err", {s_err, s_req_valid}, {1'b1, 1'b0});

        // R6: identical requests from both paths
        begin
            logic [65:0] leg, mem;
            io_cyc(1'b1, 16'h0CF8, 4'hF, mk_addr(8'd3, 5'd4, 3'd5, 6'd6));
            io_cyc(1'b1, 16'h0CFC, 4'h5, 32'hCAFE_F00D);
            leg = {s_req_valid, s_req_write, s_bus, s_dev, s_func, s_dw, s_be, s_wdata};
            mm_cyc(1'b1, 1'b0, 2'd2, mm_target(8'd3, 5'd4, 3'd5, 10'd6), 4'h5, 32'hCAFE_F00D);
            mem = {s_req_valid, s_req_write, s_bus, s_dev, s_func, s_dw, s_be, s_wdata};
            checks++;
            if (leg !== mem) begin
                fails++;
                $display("FAIL R6 got %h expected %h", mem, leg);
            end
        end

        // R8: simultaneous accesses, I/O wins
        @(negedge clk);
        io_valid = 1'b1; io_write = 1'b0; io_addr = 16'h0CFC; io_be = 4'hF;
        mm_valid = 1'b1; mm_write = 1'b0; mm_size = 2'd2;
        mm_addr = 32'hD000_0000;
        #1;
        chk("R8 tie mm_ready low", 32'(mm_ready), 32'd0);
        chk("R8 tie io_ready high", 32'(io_ready), 32'd1);
        @(negedge clk);
        io_valid = 1'b0; mm_valid = 1'b0;
        chk("R8 tie io request", {req_valid, req_bus, req_dev, req_func},
            {1'b1, 8'd3, 5'd4, 3'd5});
        chk("R8 tie mm dropped", {mm_err, mm_rvalid}, 2'b00);
        answer_read(1'b0);
        chk("R7 tie answer to io", s_rdata, exp_rsp(8'd3, 5'd4, 3'd5, 10'd6));
        chk("R7 tie mm silent", 32'(mm_rvalid), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule